// File: doc/BRIEF.md
# Pipelined Byte-Lane SRAM Core with Selectable Output Turn-Off

This block is a synchronous single-port memory with a registered command stage and a registered read-output stage. Each clock edge captures an address, a chip select, write controls and write data. A read returns its word on the data outputs after the second rising edge. Back-to-back reads stream one word per cycle, so a four-word sequence finishes in a 3-1-1-1 pattern measured from the address setup. The word is split into byte lanes of nine bits each. A write either stores the lanes chosen by a lane-select vector when the byte-write enable is high, or stores every lane when the global write is high, whatever the other write controls say.

A static mode input sets how quickly the output drivers turn off after a deselect. In single-step mode the drive stops right after the edge that captures the deselect. In two-step mode the deselect travels through the same two stages as a read. An output enable and a sleep input act on the drivers without the clock. While sleep is high, the block also turns every captured command into a deselect, so the stored contents stay untouched.

Top module: `pipe_sram_core`

## Requirements
- R1: A read is a captured cycle with `chipSel` high, `sleep` low and no write condition. Its word from `addr` appears on `rdData`, with `rdDrive` high, after the second rising edge that follows. Reads issued on consecutive edges give one word per cycle.
- R2: With `byteWrEn` high, `globalWr` low and at least one `laneSel` bit set, only the selected lanes of the word at `addr` are written. Lane i is bits [9i+8:9i]. All other lanes keep their earlier value.
- R3: With `globalWr` high, all four lanes are written, regardless of `byteWrEn` and `laneSel`.
- R4: With `byteWrEn` high, `globalWr` low and `laneSel` zero, the cycle is a read and writes nothing.
- R5: With `dualDesel` low, `rdDrive` is low after an edge that captured a deselect (`chipSel` low or `sleep` high). This applies even when the edge before it captured a read.
- R6: With `dualDesel` high, a read followed by a deselect still drives the read word after the edge that captured the deselect. The drive drops only after the next edge.
- R7: `outEn` gates `rdDrive` combinationally, with no clock. `rdData` is all zeros whenever `rdDrive` is low.
- R8: While `sleep` is high, `rdDrive` is low at once and captured writes have no effect. After sleep ends, the stored contents read back unchanged.
- R9: A captured write never causes `rdDrive` to be high after the second edge that follows it.
- R10: A read issued on the edge right after a write to the same address returns the newly written lanes.
- R11: While `rstN` is low and right after it is released, `rdDrive` is low and `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset of the control state |
| chipSel | input | 1 | Command select; low means deselect |
| addr | input | ADDR_W | Word address |
| byteWrEn | input | 1 | Enables lane-selected writes |
| laneSel | input | LANES | Per-lane write selects |
| globalWr | input | 1 | Writes all lanes, overriding the other write controls |
| wrData | input | LANES*LANE_W | Write word, taken with the write command |
| dualDesel | input | 1 | 0: single-step output turn-off, 1: two-step turn-off |
| outEn | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous sleep; blocks accesses and drive |
| rdData | output | LANES*LANE_W | Read word, zero when not driven |
| rdDrive | output | 1 | High when the data drivers are on |

## Verification
On every cycle, the bound checker checks the drive timing rules. Drive may only follow a read issued two edges earlier. A deselect in single-step mode and a write or sleep two edges back each force the drive off. In two-step mode, a read followed by a deselect keeps driving. Undriven data must be zero. The data values cannot be seen from ports alone over a short window: lane-selective writes, global override, the no-lane byte write acting as a read, read-after-write, and retention across sleep. The bench's directed scenarios and its random run show these against a reference memory model.

// File: rtl/pipe_sram_core_pkg.sv
package pipe_sram_core_pkg;

  // Kind of command held in the input register stage
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmdKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // load the address/data stage this edge
    logic memRd;    // stage holds a read: load the output register
    logic memWr;    // stage holds a write: commit enabled lanes
  } coreStrobes_t;

endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_core_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipSel,
  input  logic             byteWrEn,
  input  logic [LANES-1:0] laneSel,
  input  logic             globalWr,
  input  logic             dualDesel,
  input  logic             outEn,
  input  logic             sleep,
  output coreStrobes_t     strobes,
  output logic [LANES-1:0] laneWe,
  output logic             drive
);

  cmdKind_e         nextKind;
  logic [LANES-1:0] nextLanes;
  cmdKind_e         stageKind;
  logic [LANES-1:0] stageLanes;
  logic             outValid;

  // Decode of the command presented at the inputs
  always_comb begin
    nextKind  = CMD_IDLE;
    nextLanes = '0;
    if (chipSel && !sleep) begin
      if (globalWr) begin
        nextKind  = CMD_WRITE;
        nextLanes = '1;
      end else if (byteWrEn && (|laneSel)) begin
        nextKind  = CMD_WRITE;
        nextLanes = laneSel;
      end else begin
        nextKind  = CMD_READ;
      end
    end
  end

  // Input register stage and output-valid stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageKind  <= CMD_IDLE;
      stageLanes <= '0;
      outValid   <= 1'b0;
    end else begin
      stageKind  <= nextKind;
      stageLanes <= nextLanes;
      outValid   <= (stageKind == CMD_READ);
    end
  end

  always_comb begin
    strobes.capture = (nextKind != CMD_IDLE);
    strobes.memRd   = (stageKind == CMD_READ);
    strobes.memWr   = (stageKind == CMD_WRITE);
    laneWe          = stageLanes;
  end

  // Single-step mode cuts drive as soon as a deselect sits in the input stage;
  // two-step mode waits for the deselect to reach the output stage.
  logic turnOffEarly;
  assign turnOffEarly = !dualDesel && (stageKind == CMD_IDLE);
  assign drive        = outValid && !turnOffEarly && outEn && !sleep;

endmodule

// File: rtl/pipe_sram_datapath.sv
module pipe_sram_datapath
  import pipe_sram_core_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  coreStrobes_t            strobes,
  input  logic [LANES-1:0]        laneWe,
  input  logic                    drive,
  output logic [LANES*LANE_W-1:0] rdData
);

  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned WORD_W = LANES * LANE_W;

  logic [ADDR_W-1:0] stageAddr;
  logic [WORD_W-1:0] stageData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageAddr <= '0;
      stageData <= '0;
    end else if (strobes.capture) begin
      stageAddr <= addr;
      stageData <= wrData;
    end
  end

  // One storage array and one output register per byte lane
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneOut;

    always_ff @(posedge clk) begin
      if (strobes.memWr && laneWe[g])
        laneMem[stageAddr] <= stageData[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        laneOut <= '0;
      else if (strobes.memRd)
        laneOut <= laneMem[stageAddr];
    end

    assign rdData[g*LANE_W +: LANE_W] = drive ? laneOut : '0;
  end

endmodule

// File: rtl/pipe_sram_core.sv
module pipe_sram_core
  import pipe_sram_core_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    chipSel,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    byteWrEn,
  input  logic [LANES-1:0]        laneSel,
  input  logic                    globalWr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    dualDesel,
  input  logic                    outEn,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdDrive
);

  coreStrobes_t     strobes;
  logic [LANES-1:0] laneWe;

  pipe_sram_ctrl #(.LANES(LANES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .chipSel  (chipSel),
    .byteWrEn (byteWrEn),
    .laneSel  (laneSel),
    .globalWr (globalWr),
    .dualDesel(dualDesel),
    .outEn    (outEn),
    .sleep    (sleep),
    .strobes  (strobes),
    .laneWe   (laneWe),
    .drive    (rdDrive)
  );

  pipe_sram_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wrData (wrData),
    .strobes(strobes),
    .laneWe (laneWe),
    .drive  (rdDrive),
    .rdData (rdData)
  );

endmodule

// File: rtl/pipe_sram_core_chk.sv
module pipe_sram_core_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    chipSel,
  input logic                    byteWrEn,
  input logic [LANES-1:0]        laneSel,
  input logic                    globalWr,
  input logic                    dualDesel,
  input logic                    outEn,
  input logic                    sleep,
  input logic [LANES*LANE_W-1:0] rdData,
  input logic                    rdDrive
);

  logic idleCmd, writeCmd, readCmd;
  assign idleCmd  = !chipSel || sleep;
  assign writeCmd = !idleCmd && (globalWr || (byteWrEn && (|laneSel)));
  assign readCmd  = !idleCmd && !writeCmd;

  // Edges seen since reset release, saturating; guards $past windows
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) && rdDrive |-> $past(readCmd, 2));  // R1

  AST_SCD_CUTOFF: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd1) && !dualDesel && $past(idleCmd) |-> !rdDrive);  // R5

  AST_DCD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) && dualDesel && $past(readCmd, 2) && $past(idleCmd)
      && outEn && !sleep |-> rdDrive);  // R6

  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdDrive |-> (rdData == '0));  // R7

  AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) && $past(sleep, 2) |-> !rdDrive);  // R8

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2) && $past(writeCmd, 2) |-> !rdDrive);  // R9

endmodule

bind pipe_sram_core pipe_sram_core_chk #(.LANES(LANES), .LANE_W(LANE_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .chipSel  (chipSel),
  .byteWrEn (byteWrEn),
  .laneSel  (laneSel),
  .globalWr (globalWr),
  .dualDesel(dualDesel),
  .outEn    (outEn),
  .sleep    (sleep),
  .rdData   (rdData),
  .rdDrive  (rdDrive)
);

// File: tb/pipe_sram_core_test.sv
module pipe_sram_core_test;

  localparam int ADDR_W = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              chipSel = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              byteWrEn = 1'b0;
  logic [LANES-1:0]  laneSel = '0;
  logic              globalWr = 1'b0;
  logic [WORD_W-1:0] wrData = '0;
  logic              dualDesel = 1'b0;
  logic              outEn = 1'b1;
  logic              sleep = 1'b0;
  logic [WORD_W-1:0] rdData;
  logic              rdDrive;

  pipe_sram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .addr(addr), .byteWrEn(byteWrEn),
    .laneSel(laneSel), .globalWr(globalWr), .wrData(wrData), .dualDesel(dualDesel),
    .outEn(outEn), .sleep(sleep), .rdData(rdData), .rdDrive(rdDrive)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [WORD_W-1:0] model [DEPTH];
  int                lastKind = 0, prevKind = 0;   // 0 idle, 1 read, 2 write
  logic [WORD_W-1:0] lastData = '0, prevData = '0;

  function automatic int kindOf();
    if (!chipSel || sleep) return 0;
    if (globalWr || (byteWrEn && (|laneSel))) return 2;
    return 1;
  endfunction

  function automatic logic [LANES-1:0] lanesOf();
    return globalWr ? '1 : laneSel;
  endfunction

  function automatic logic expDrive();
    return (prevKind == 1) && (dualDesel || lastKind != 0) && outEn && !sleep;
  endfunction

  function automatic string autoTag();
    if (sleep) return "R8";
    if (!outEn) return "R7";
    if (prevKind == 2) return "R9";
    if (prevKind == 1 && lastKind == 0) return dualDesel ? "R6" : "R5";
    return "R1";
  endfunction

  task automatic checkOut(input string tag);
    logic              ed;
    logic [WORD_W-1:0] ev;
    ed = expDrive();
    ev = ed ? prevData : '0;
    checks++;
    if (rdDrive !== ed || rdData !== ev) begin
      failures++;
      $display("FAIL %s drive=%0b data=%h expected drive=%0b data=%h",
               tag, rdDrive, rdData, ed, ev);
    end
  endtask

  // Inputs are already driven; apply one edge and check at the next falling edge
  task automatic tick(input string tag);
    int                k;
    logic [WORD_W-1:0] pend;
    logic [LANES-1:0]  ln;
    k    = kindOf();
    pend = '0;
    if (k == 1) pend = model[addr];
    if (k == 2) begin
      ln = lanesOf();
      for (int i = 0; i < LANES; i++)
        if (ln[i]) model[addr][i*LANE_W +: LANE_W] = wrData[i*LANE_W +: LANE_W];
    end
    @(posedge clk);
    prevKind = lastKind; prevData = lastData;
    lastKind = k;        lastData = pend;
    @(negedge clk);
    checkOut(tag == "" ? autoTag() : tag);
  endtask

  task automatic setRead(input logic [ADDR_W-1:0] a);
    chipSel = 1; addr = a; byteWrEn = 0; laneSel = '0; globalWr = 0;
  endtask

  task automatic setWrite(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] ln,
                          input logic gw, input logic [WORD_W-1:0] d);
    chipSel = 1; addr = a; byteWrEn = 1; laneSel = ln; globalWr = gw; wrData = d;
  endtask

  task automatic setIdle();
    chipSel = 0; byteWrEn = 0; laneSel = '0; globalWr = 0;
  endtask

  function automatic logic [WORD_W-1:0] rndWord();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    checks++;
    if (rdDrive !== 1'b0 || rdData !== '0) begin
      failures++;
      $display("FAIL R11 drive=%0b data=%h expected drive=0 data=0", rdDrive, rdData);
    end
    rstN = 1;
    @(negedge clk);
    checkOut("R11");

    // R3: fill every word by global write with random lane selects, byteWrEn low
    for (int a = 0; a < DEPTH; a++) begin
      setWrite(a[ADDR_W-1:0], 4'($urandom), 1'b1, rndWord());
      byteWrEn = 0;
      tick("R3");
    end
    setIdle(); tick("R9");

    // R1: back-to-back reads of all words
    for (int a = 0; a < DEPTH; a++) begin
      setRead(a[ADDR_W-1:0]);
      tick("R1");
    end
    setIdle(); tick("R1"); tick("R5");

    // R2 + R10: lane write followed directly by a read of the same word
    setWrite(6'd5, 4'b0101, 1'b0, rndWord()); tick("R2");
    setRead(6'd5); tick("R9");
    setRead(6'd5); tick("R10");
    setIdle(); tick("R10"); tick("R2");

    // R4: byte-write enable with no lane is a read
    setWrite(6'd6, 4'b0000, 1'b0, rndWord()); tick("R4");
    setRead(6'd6); tick("R4");
    setIdle(); tick("R4"); tick("R4");

    // R3: global write overrides lane selects
    setWrite(6'd9, 4'b0001, 1'b1, rndWord()); tick("R3");
    setRead(6'd9); tick("R3");
    setIdle(); tick("R3"); tick("R3");

    // R5: single-step turn-off
    dualDesel = 0;
    setRead(6'd7); tick("R5");
    setIdle(); tick("R5"); tick("R5");
    // R6: two-step turn-off
    dualDesel = 1;
    setRead(6'd7); tick("R6");
    setIdle(); tick("R6"); tick("R6");

    // R7: output enable acts between edges
    setRead(6'd10); tick("R7");
    setRead(6'd11); tick("R7");
    #1 outEn = 0; #1 checkOut("R7");
    #1 outEn = 1; #1 checkOut("R7");
    setIdle(); tick("R7"); tick("R7");

    // R8: sleep cuts drive at once, blocks writes, keeps contents
    setRead(6'd8); tick("R8");
    setIdle(); #1 sleep = 1; #1 checkOut("R8");
    setWrite(6'd8, 4'b1111, 1'b1, rndWord()); tick("R8"); tick("R8");
    sleep = 0;
    setRead(6'd8); tick("R8");
    setIdle(); tick("R8"); tick("R8");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      if (n % 200 == 0) dualDesel = $urandom_range(0, 1);
      r = $urandom_range(0, 99);
      outEn = ($urandom_range(0, 9) != 0);
      sleep = ($urandom_range(0, 29) == 0);
      if (r < 15) setIdle();
      else if (r < 55) setRead(6'($urandom));
      else setWrite(6'($urandom), 4'($urandom), ($urandom_range(0, 7) == 0), rndWord());
      if (r >= 55) byteWrEn = $urandom_range(0, 1);
      tick("");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule